// File: doc/BRIEF.md
# Interrupt Routing Controller Register Window

This block is the software-facing register front end of an interrupt routing controller. Software sees just two addressable locations: an 8-bit register select and a 32-bit data window. The value held in the select register decides what the window reaches. That can be the controller identification register, a read-only version word, an arbitration identifier, or one 32-bit half of a 64-bit redirection entry. There is one redirection entry per interrupt pin.

Each redirection entry holds the following fields: vector, delivery mode, destination mode, remote-IRR, trigger mode, mask and destination ID. The complete table is exported as a flat vector for the delivery and end-of-interrupt logic, which live outside this block. That external logic uses a dedicated port to set or clear an entry's remote-IRR flag. Whenever a software write flips an entry's mask bit, the block emits a single-cycle event carrying the pin number and the new mask value.

Top module: `irq_route_regwin`

## Requirements
- R1: Only address bits 7:0 are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Any other offset reads as 0x00000000, and writes to it change nothing.
- R2: A select write stores only data bits 7:0. A select read returns that byte zero-extended to 32 bits.
- R3: With select 0x00, a window read returns the 4-bit ID in bits 27:24, and a window write loads the ID from data bits 27:24. With select 0x02, a window read returns the same word as select 0x00, and window writes are ignored.
- R4: With select 0x01, a window read returns (NPINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Writes have no effect.
- R5: A select value of 0x10 or above addresses entry (select-0x10)>>1. Select bit 0 = 1 reaches entry bits 63:32, and select bit 0 = 0 reaches bits 31:0. Writing one half leaves the other half intact. The layout is: vector 7:0, delivery mode 10:8, destination mode 11, remote-IRR 14, trigger mode 15 (1 = level), mask 16, destination ID 63:56. Entry i appears at table_flat[64*i+63:64*i].
- R6: An entry index at or beyond NPINS reads as 0xFFFFFFFF, and writes to it are discarded. Select values 0x03 to 0x0F count as out of range.
- R7: A write to the lower half of an entry forces its remote-IRR bit to 0. A write to the upper half leaves remote-IRR unchanged.
- R8: A window write that changes an entry's mask bit raises mask_evt_valid for exactly the next cycle, with mask_evt_pin and mask_evt_value set. A write that leaves the mask bit unchanged raises no event.
- R9: After reset, the select and ID registers are 0, and every entry reads 0x0000000000010000 (only the mask bit set).
- R10: Read data and rd_valid appear in the cycle after a read strobe. rd_valid is high for that one cycle only.
- R11: bus_size 0 (byte) and 1 (halfword) zero-extend the low 8 or 16 data bits before decoding. Values 2 and 3 use the full word.
- R12: rirr_we loads rirr_val into the remote-IRR bit of entry rirr_pin. A pin at or beyond NPINS is ignored. A same-cycle lower-half software write to the same entry wins, leaving remote-IRR at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Access address; bits 7:0 decoded |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 32 | Registered read data |
| rirr_we | input | 1 | Remote-IRR update strobe from delivery logic |
| rirr_pin | input | PIN_W | Entry whose remote-IRR is updated |
| rirr_val | input | 1 | New remote-IRR value |
| table_flat | output | NPINS*64 | All redirection entries, entry i at bits 64*i+63:64*i |
| mask_evt_valid | output | 1 | Mask-change event |
| mask_evt_pin | output | PIN_W | Pin whose mask changed |
| mask_evt_value | output | 1 | New mask value |

## Verification
The assertions assume that the inputs carry known values once reset is released. They also assume that bus_req is low while reset is asserted, so no access is mistaken for one made before reset. Each access is a single-cycle strobe, one per cycle, and bus_addr is at least 8 bits wide. The stimulus meets these assumptions by driving every input on the falling clock edge, holding all strobes low throughout reset, and issuing accesses strictly one after another. The remote-IRR port is pulsed for one cycle at a time and is driven together with a bus write only in the deliberate collision test.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam logic [7:0] OFS_SELECT     = 8'h00;
    localparam logic [7:0] OFS_WINDOW     = 8'h10;

    localparam logic [7:0] SEL_IDENT      = 8'h00;
    localparam logic [7:0] SEL_VERSION    = 8'h01;
    localparam logic [7:0] SEL_ARBIT      = 8'h02;
    localparam logic [7:0] SEL_TABLE_BASE = 8'h10;

    localparam logic [1:0] SZ_BYTE        = 2'd0;
    localparam logic [1:0] SZ_HALF        = 2'd1;

    localparam logic [63:0] ENTRY_RESET   = 64'h0000_0000_0001_0000;

    // One redirection entry, msb first
    typedef struct packed {
        logic [7:0]  dest;      // 63:56
        logic [38:0] spare_hi;  // 55:17
        logic        mask;      // 16
        logic        level;     // 15
        logic        rirr;      // 14
        logic [1:0]  spare_lo;  // 13:12
        logic        dmode;     // 11
        logic [2:0]  dlv;       // 10:8
        logic [7:0]  vec;       // 7:0
    } redir_t;

    function automatic logic [7:0] entry_index(input logic [7:0] sel);
        logic [7:0] off;
        off = sel - SEL_TABLE_BASE;
        return off >> 1;
    endfunction

    function automatic logic [31:0] zext_data(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            SZ_BYTE: return {24'h0, d[7:0]};
            SZ_HALF: return {16'h0, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/irw_bus_front.sv
module irw_bus_front
    import irw_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [31:0]   bus_wdata,
    output logic          wr_select,
    output logic          wr_window,
    output logic          rd_select,
    output logic          rd_window,
    output logic          rd_strobe,
    output logic [31:0]   wdata_ext
);

    logic [7:0] ofs;
    logic       hit_sel;
    logic       hit_win;

    always_comb begin
        ofs       = bus_addr[7:0];
        hit_sel   = (ofs == OFS_SELECT);
        hit_win   = (ofs == OFS_WINDOW);
        wr_select = bus_req &  bus_we & hit_sel;
        wr_window = bus_req &  bus_we & hit_win;
        rd_select = bus_req & ~bus_we & hit_sel;
        rd_window = bus_req & ~bus_we & hit_win;
        rd_strobe = bus_req & ~bus_we;
        wdata_ext = zext_data(bus_size, bus_wdata);
    end

endmodule

// File: rtl/irw_regfile.sv
module irw_regfile
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_select,
    input  logic                   wr_window,
    input  logic [31:0]            wdata,
    input  logic                   rirr_we,
    input  logic [PIN_W-1:0]       rirr_pin,
    input  logic                   rirr_val,
    output logic [7:0]             sel_o,
    output logic [3:0]             id_o,
    output redir_t [NPINS-1:0]     tbl_o,
    output logic                   mevt_valid_o,
    output logic [PIN_W-1:0]       mevt_pin_o,
    output logic                   mevt_mask_o
);

    typedef struct packed {
        logic [7:0]            sel;
        logic [3:0]            id;
        redir_t [NPINS-1:0]    tbl;
        logic                  ev;
        logic [PIN_W-1:0]      ev_pin;
        logic                  ev_mask;
    } state_t;

    state_t           st_d, st_q;
    logic [7:0]       idx;
    logic             in_rng;
    logic [PIN_W-1:0] pin;
    logic             old_mask;
    redir_t           ent;

    always_comb begin
        st_d     = st_q;
        st_d.ev  = 1'b0;
        ent      = '0;
        old_mask = 1'b0;
        idx      = entry_index(st_q.sel);
        in_rng   = (st_q.sel >= SEL_TABLE_BASE) && (32'(idx) < 32'(NPINS));
        pin      = PIN_W'(idx);

        // delivery-side remote-IRR update first; a software write below overrides it
        if (rirr_we && (32'(rirr_pin) < 32'(NPINS))) begin
            st_d.tbl[rirr_pin].rirr = rirr_val;
        end

        if (wr_select) begin
            st_d.sel = wdata[7:0];
        end

        if (wr_window) begin
            if (st_q.sel == SEL_IDENT) begin
                st_d.id = wdata[27:24];
            end else if (in_rng) begin
                ent      = st_d.tbl[pin];
                old_mask = st_q.tbl[pin].mask;
                if (st_q.sel[0]) begin
                    ent[63:32] = wdata;
                end else begin
                    ent[31:0]  = wdata;
                    ent.rirr   = 1'b0;
                end
                st_d.tbl[pin] = ent;
                if (ent.mask != old_mask) begin
                    st_d.ev      = 1'b1;
                    st_d.ev_pin  = pin;
                    st_d.ev_mask = ent.mask;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel     <= '0;
            st_q.id      <= '0;
            st_q.ev      <= 1'b0;
            st_q.ev_pin  <= '0;
            st_q.ev_mask <= 1'b0;
            for (int i = 0; i < NPINS; i++) begin
                st_q.tbl[i] <= ENTRY_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o        = st_q.sel;
    assign id_o         = st_q.id;
    assign tbl_o        = st_q.tbl;
    assign mevt_valid_o = st_q.ev;
    assign mevt_pin_o   = st_q.ev_pin;
    assign mevt_mask_o  = st_q.ev_mask;

endmodule

// File: rtl/irw_rdpath.sv
module irw_rdpath
    import irw_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter int         PIN_W   = 5,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_select,
    input  logic               rd_window,
    input  logic               rd_strobe,
    input  logic [7:0]         sel,
    input  logic [3:0]         id,
    input  redir_t [NPINS-1:0] tbl,
    output logic               rd_valid_o,
    output logic [31:0]        rd_data_o
);

    localparam logic [7:0] TOP_PIN = 8'(NPINS - 1);

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } rd_t;

    rd_t              rd_d, rd_q;
    logic [7:0]       idx;
    logic             in_rng;
    logic [PIN_W-1:0] pin;
    logic [63:0]      ent;
    logic [31:0]      win_word;

    always_comb begin
        idx    = entry_index(sel);
        in_rng = (sel >= SEL_TABLE_BASE) && (32'(idx) < 32'(NPINS));
        pin    = PIN_W'(idx);
        ent    = in_rng ? tbl[pin] : '1;

        case (sel)
            SEL_IDENT,
            SEL_ARBIT:   win_word = {4'h0, id, 24'h0};
            SEL_VERSION: win_word = {8'h00, TOP_PIN, 8'h00, VERSION};
            default:     win_word = sel[0] ? ent[63:32] : ent[31:0];
        endcase

        rd_d       = rd_q;
        rd_d.valid = rd_strobe;
        if (rd_strobe) begin
            if (rd_select)      rd_d.data = {24'h0, sel};
            else if (rd_window) rd_d.data = win_word;
            else                rd_d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_data_o  = rd_q.data;

endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter  int         NPINS   = 24,
    parameter  int         AW      = 12,
    parameter  logic [7:0] VERSION = 8'h11,
    localparam int         PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic                  rd_valid,
    output logic [31:0]           rd_data,
    input  logic                  rirr_we,
    input  logic [PIN_W-1:0]      rirr_pin,
    input  logic                  rirr_val,
    output logic [NPINS*64-1:0]   table_flat,
    output logic                  mask_evt_valid,
    output logic [PIN_W-1:0]      mask_evt_pin,
    output logic                  mask_evt_value
);

    logic               wr_select, wr_window;
    logic               rd_select, rd_window, rd_strobe;
    logic [31:0]        wdata_ext;
    logic [7:0]         sel_q;
    logic [3:0]         id_q;
    redir_t [NPINS-1:0] tbl;

    irw_bus_front #(.AW(AW)) u_front (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .wr_select (wr_select),
        .wr_window (wr_window),
        .rd_select (rd_select),
        .rd_window (rd_window),
        .rd_strobe (rd_strobe),
        .wdata_ext (wdata_ext)
    );

    irw_regfile #(.NPINS(NPINS), .PIN_W(PIN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_select    (wr_select),
        .wr_window    (wr_window),
        .wdata        (wdata_ext),
        .rirr_we      (rirr_we),
        .rirr_pin     (rirr_pin),
        .rirr_val     (rirr_val),
        .sel_o        (sel_q),
        .id_o         (id_q),
        .tbl_o        (tbl),
        .mevt_valid_o (mask_evt_valid),
        .mevt_pin_o   (mask_evt_pin),
        .mevt_mask_o  (mask_evt_value)
    );

    irw_rdpath #(.NPINS(NPINS), .PIN_W(PIN_W), .VERSION(VERSION)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_select  (rd_select),
        .rd_window  (rd_window),
        .rd_strobe  (rd_strobe),
        .sel        (sel_q),
        .id         (id_q),
        .tbl        (tbl),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_flat
        assign table_flat[g*64 +: 64] = tbl[g];
    end

endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
    parameter int         NPINS   = 24,
    parameter int         AW      = 12,
    parameter logic [7:0] VERSION = 8'h11,
    parameter int         PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [AW-1:0]        bus_addr,
    input logic                 rd_valid,
    input logic [31:0]          rd_data,
    input logic [7:0]           sel_q,
    input logic [NPINS*64-1:0]  table_flat,
    input logic                 mask_evt_valid,
    input logic [PIN_W-1:0]     mask_evt_pin,
    input logic                 mask_evt_value
);

    logic       is_rd, is_wr, at_sel, at_win, in_tbl, lo_hit;
    logic [7:0] idx;
    logic       lo_hit_q;
    logic [7:0] lo_idx_q;

    always_comb begin
        is_rd  = bus_req && !bus_we;
        is_wr  = bus_req && bus_we;
        at_sel = (bus_addr[7:0] == 8'h00);
        at_win = (bus_addr[7:0] == 8'h10);
        idx    = 8'(sel_q - 8'h10) >> 1;
        in_tbl = (sel_q >= 8'h10) && (32'(idx) < 32'(NPINS));
        lo_hit = is_wr && at_win && in_tbl && !sel_q[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hit_q <= 1'b0;
            lo_idx_q <= '0;
        end else begin
            lo_hit_q <= lo_hit;
            lo_idx_q <= idx;
        end
    end

    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !at_sel && !at_win) |=> (rd_data == 32'h0)); // R1

    AST_SEL_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && at_sel) |=> (rd_data[31:8] == 24'h0)); // R2

    AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && at_win && sel_q == 8'h01)
        |=> (rd_data == {8'h00, 8'(NPINS - 1), 8'h00, VERSION})); // R4

    AST_OOR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && at_win && sel_q >= 8'h03 && !in_tbl) |=> (rd_data == 32'hFFFF_FFFF)); // R6

    AST_LOW_WR_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        lo_hit_q |-> (table_flat[32'(lo_idx_q) * 64 + 14] == 1'b0)); // R7

    AST_MASK_EVT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> (table_flat[32'(mask_evt_pin) * 64 + 16] == mask_evt_value)); // R8

    AST_MASK_EVT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> $past(is_wr && at_win)); // R8

    AST_RD_VALID_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid); // R10

    AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_rd)); // R10

endmodule

bind irq_route_regwin irw_checker #(
    .NPINS   (NPINS),
    .AW      (AW),
    .VERSION (VERSION)
) u_irw_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .sel_q          (sel_q),
    .table_flat     (table_flat),
    .mask_evt_valid (mask_evt_valid),
    .mask_evt_pin   (mask_evt_pin),
    .mask_evt_value (mask_evt_value)
);

// File: tb/irq_route_regwin_bench.sv
module irq_route_regwin_bench;

    localparam int NPINS = 24;
    localparam int AW    = 12;
    localparam int PIN_W = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_req = 1'b0;
    logic                 bus_we = 1'b0;
    logic [AW-1:0]        bus_addr = '0;
    logic [1:0]           bus_size = 2'd2;
    logic [31:0]          bus_wdata = '0;
    logic                 rd_valid;
    logic [31:0]          rd_data;
    logic                 rirr_we = 1'b0;
    logic [PIN_W-1:0]     rirr_pin = '0;
    logic                 rirr_val = 1'b0;
    logic [NPINS*64-1:0]  table_flat;
    logic                 mask_evt_valid;
    logic [PIN_W-1:0]     mask_evt_pin;
    logic                 mask_evt_value;

    int n_chk  = 0;
    int n_fail = 0;

    logic             ev_v, ev_m;
    logic [PIN_W-1:0] ev_p;
    logic [31:0]      rdat;
    logic             rval;
    logic [NPINS*64-1:0] snap;

    always #2.5 clk = ~clk;

    irq_route_regwin #(.NPINS(NPINS), .AW(AW), .VERSION(8'h11)) u_irq_route_regwin (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rirr_we(rirr_we),
        .rirr_pin(rirr_pin), .rirr_val(rirr_val), .table_flat(table_flat),
        .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
        .mask_evt_value(mask_evt_value)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] data;   // write data, or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 2'd2, 32'h0000_0001, 8'd2},  // R2 select version
        '{1'b1, 12'h010, 2'd2, 32'h0017_0011, 8'd4},  // R4
        '{1'b0, 12'h010, 2'd2, 32'hFFFF_FFFF, 8'd4},  // R4 write ignored
        '{1'b1, 12'h010, 2'd2, 32'h0017_0011, 8'd4},
        '{1'b0, 12'h000, 2'd2, 32'h0000_0000, 8'd3},  // R3 ID
        '{1'b0, 12'h010, 2'd2, 32'h0A00_0000, 8'd3},
        '{1'b1, 12'h010, 2'd2, 32'h0A00_0000, 8'd3},
        '{1'b0, 12'h000, 2'd2, 32'h0000_0002, 8'd3},  // R3 arbitration
        '{1'b0, 12'h010, 2'd2, 32'h0500_0000, 8'd3},
        '{1'b1, 12'h010, 2'd2, 32'h0A00_0000, 8'd3},
        '{1'b1, 12'h000, 2'd2, 32'h0000_0002, 8'd2},  // R2 read select
        '{1'b0, 12'h000, 2'd2, 32'h0000_1234, 8'd2},  // R2 keeps 0x34
        '{1'b1, 12'h000, 2'd2, 32'h0000_0034, 8'd2},
        '{1'b1, 12'h010, 2'd2, 32'h0001_0000, 8'd9},  // R9 entry 18 low reset
        '{1'b0, 12'h010, 2'd2, 32'h0000_C0A5, 8'd7},  // R7 rirr bit dropped
        '{1'b1, 12'h010, 2'd2, 32'h0000_80A5, 8'd7},
        '{1'b0, 12'h000, 2'd2, 32'h0000_0035, 8'd5},  // R5 upper half
        '{1'b0, 12'h010, 2'd2, 32'hAB00_0000, 8'd5},
        '{1'b1, 12'h010, 2'd2, 32'hAB00_0000, 8'd5},
        '{1'b0, 12'h000, 2'd2, 32'h0000_0034, 8'd5},
        '{1'b1, 12'h010, 2'd2, 32'h0000_80A5, 8'd5},  // R5 low half intact
        '{1'b0, 12'h000, 2'd2, 32'h0000_000F, 8'd6},  // R6 gap select
        '{1'b1, 12'h010, 2'd2, 32'hFFFF_FFFF, 8'd6},
        '{1'b0, 12'h000, 2'd2, 32'h0000_0040, 8'd6},  // R6 index 24
        '{1'b1, 12'h010, 2'd2, 32'hFFFF_FFFF, 8'd6},
        '{1'b1, 12'h020, 2'd2, 32'h0000_0000, 8'd1},  // R1 other offset
        '{1'b0, 12'h020, 2'd2, 32'h0000_0077, 8'd1},
        '{1'b1, 12'h000, 2'd2, 32'h0000_0040, 8'd1},  // R1 select unchanged
        '{1'b1, 12'h140, 2'd2, 32'h0000_0000, 8'd1},
        '{1'b0, 12'h100, 2'd0, 32'h0000_0003, 8'd1},  // R1 high bits ignored
        '{1'b1, 12'h000, 2'd2, 32'h0000_0003, 8'd1},
        '{1'b0, 12'h000, 2'd1, 32'hFFFF_1234, 8'd11}, // R11 halfword
        '{1'b1, 12'h000, 2'd2, 32'h0000_0034, 8'd11},
        '{1'b0, 12'h000, 2'd0, 32'h0000_0000, 8'd11},
        '{1'b0, 12'h110, 2'd0, 32'h0F00_0000, 8'd11}, // R11 byte clears ID
        '{1'b1, 12'h010, 2'd2, 32'h0000_0000, 8'd11}
    };

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        ev_v = mask_evt_valid; ev_p = mask_evt_pin; ev_m = mask_evt_value;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = 2'd2;
        @(negedge clk);
        rdat = rd_data; rval = rd_valid;
        bus_req = 1'b0;
    endtask

    task automatic rirr_pulse(input logic [PIN_W-1:0] p, input logic v);
        @(negedge clk);
        rirr_we = 1'b1; rirr_pin = p; rirr_val = v;
        @(negedge clk);
        rirr_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired, run hung");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        for (int i = 0; i < NPINS; i++) begin
            chk(table_flat[i*64 +: 64] == 64'h1_0000, "R9 entry reset", table_flat[i*64 +: 64], 64'h1_0000);
        end
        chk(rd_valid == 1'b0 && mask_evt_valid == 1'b0, "R9 outputs idle", {rd_valid, mask_evt_valid}, 0);
        bus_rd(12'h000);
        chk(rdat == 32'h0, "R9 select reset", rdat, 0);
        bus_rd(12'h010);
        chk(rdat == 32'h0, "R9 ID reset", rdat, 0);

        // R10 read latency and single-cycle valid
        chk(rval == 1'b1, "R10 valid after read", rval, 1);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 valid one cycle", rd_valid, 0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].rd) begin
                bus_rd(VECS[k].addr);
                chk(rdat == VECS[k].data && rval, $sformatf("R%0d vector %0d", VECS[k].req, k), rdat, VECS[k].data);
            end else begin
                bus_wr(VECS[k].addr, VECS[k].size, VECS[k].data);
            end
        end

        // R5 exported layout of entry 18
        chk(table_flat[18*64 +: 64] == 64'hAB00_0000_0000_80A5, "R5 table export", table_flat[18*64 +: 64], 64'hAB00_0000_0000_80A5);

        // R8 mask-change events
        bus_wr(12'h000, 2'd2, 32'h10);
        bus_wr(12'h010, 2'd2, 32'h0000_0031);
        chk(ev_v && ev_p == 0 && ev_m == 1'b0, "R8 unmask event", {ev_v, ev_p, ev_m}, {1'b1, 5'd0, 1'b0});
        @(negedge clk);
        chk(mask_evt_valid == 1'b0, "R8 event one cycle", mask_evt_valid, 0);
        bus_wr(12'h010, 2'd2, 32'h0000_0031);
        chk(ev_v == 1'b0, "R8 no event when unchanged", ev_v, 0);
        bus_wr(12'h010, 2'd2, 32'h0001_0031);
        chk(ev_v && ev_p == 0 && ev_m == 1'b1, "R8 mask event", {ev_v, ev_p, ev_m}, {1'b1, 5'd0, 1'b1});
        bus_wr(12'h000, 2'd2, 32'h3E);
        bus_wr(12'h010, 2'd2, 32'h0000_0000);
        chk(ev_v && ev_p == 5'd23 && ev_m == 1'b0, "R8 last pin event", {ev_v, ev_p, ev_m}, {1'b1, 5'd23, 1'b0});

        // R12 remote-IRR port, R7 upper half keeps it
        rirr_pulse(5'd0, 1'b1);
        chk(table_flat[14] == 1'b1, "R12 rirr set", table_flat[14], 1);
        bus_wr(12'h000, 2'd2, 32'h11);
        bus_wr(12'h010, 2'd2, 32'h2200_0000);
        chk(table_flat[14] == 1'b1, "R7 upper write keeps rirr", table_flat[14], 1);
        chk(table_flat[63:56] == 8'h22, "R5 dest field", table_flat[63:56], 8'h22);
        bus_wr(12'h000, 2'd2, 32'h10);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0001_4031;
        rirr_we = 1'b1; rirr_pin = 5'd0; rirr_val = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; rirr_we = 1'b0;
        chk(table_flat[14] == 1'b0, "R12 software write wins", table_flat[14], 0);
        rirr_pulse(5'd3, 1'b1);
        rirr_pulse(5'd3, 1'b0);
        chk(table_flat[3*64+14] == 1'b0, "R12 rirr clear", table_flat[3*64+14], 0);
        snap = table_flat;
        rirr_pulse(5'd30, 1'b1);
        chk(table_flat == snap, "R12 out-of-range pin ignored", 0, 0);

        // R6 discarded writes
        bus_wr(12'h000, 2'd2, 32'h40);
        snap = table_flat;
        bus_wr(12'h010, 2'd2, 32'h0000_0000);
        chk(table_flat == snap && ev_v == 1'b0, "R6 write beyond table", ev_v, 0);
        bus_wr(12'h000, 2'd2, 32'h05);
        bus_wr(12'h010, 2'd2, 32'h0000_0000);
        chk(table_flat == snap, "R6 write in gap select", 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule